// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block takes bit-serial stereo audio from an external converter over three lines: a bit clock, a word-select (frame-sync) line and a data line. It delivers left and right sample words, each paired with a one-cycle valid strobe, in the system clock domain. The bit clock is unrelated to the system clock. All three lines pass through multi-stage synchronizers, and the chosen bit-clock edge is then found by edge detection. Word select and data are taken on that same edge.

Three framings can be chosen:
- **Standard stereo framing.** Each channel's MSB comes one bit after the word-select change. Word select low means left, high means right.
- **LSB-first framing.** The word length is programmable from 1 to 16 bits and is aligned to the word-select change.
- **Long-frame mode.** Frames of up to 512 bits open on a word-select rising edge. The two words sit at a programmed position, and a qualifier bit at another programmed position decides whether the frame's pair is delivered.

After reset the block is a timing slave and its clock and word-select drivers are disabled. In master mode a local divider produces the bit clock and word select. These are driven out and also fed to the receiver's own input path.

Top module: `serAudioRx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, outValid, outLeft and outRight are 0 and both output enables (sckOe, wsOe) are 0.
- R2: cfgFallEdge=0 samples data and word select on the rising bit-clock edge; cfgFallEdge=1 samples them on the falling edge.
- R3: With cfgMode=0, the bit after each word-select change is the MSB of a 16-bit word. Word select 0 means left and 1 means right. Bits after the 16th are ignored. A pair is delivered once the right word's 16th bit is in.
- R4: With cfgMode=1, a word has cfgLenM1+1 bits, starting LSB first with the word-select change. It is delivered left-aligned in 16 bits, with the unused low bits 0. Later bits are ignored. A pair is delivered after the right word's last bit.
- R5: With cfgMode=2, a frame starts on a word-select rising edge, which is bit 0. The left word, MSB first, occupies bits cfgStart to cfgStart+15, and the right word follows directly after it. The frame's pair is delivered on the next frame start only if the bit at position cfgQual was 1; if that bit was 0, no pair is delivered.
- R6: In cfgMode=2 with cfgStart=0 and cfgQual=0, one frame-start edge both delivers the previous pair and takes in the new frame's left MSB and qualifier. Both results are correct.
- R7: outValid is high for exactly one cycle per pair. outLeft and outRight change only in that cycle and hold their values otherwise.
- R8: With cfgMode=3, no pair is ever delivered.
- R9: With cfgMaster=1, sckOe and wsOe are 1 from the cycle after it is set. sckOut toggles every cfgHalfDiv+1 system cycles. wsOut toggles every cfgWsBits+1 bit periods, on the edge opposite the sampling edge. The receiver decodes the generated clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgMaster | input | 1 | 1: generate bit clock and word select locally |
| cfgFallEdge | input | 1 | 1: sample on falling bit-clock edge |
| cfgMode | input | 2 | 0 standard, 1 LSB-first, 2 long frame, 3 off |
| cfgLenM1 | input | 4 | LSB-first word length minus one |
| cfgStart | input | 9 | Long-frame bit position of the left MSB |
| cfgQual | input | 9 | Long-frame bit position of the qualifier |
| cfgHalfDiv | input | 8 | Master bit-clock half period minus one, in system cycles |
| cfgWsBits | input | 9 | Master word-select half period minus one, in bits |
| sckIn | input | 1 | Bit clock from the converter (slave) |
| wsIn | input | 1 | Word select from the converter (slave) |
| sdIn | input | 1 | Serial data |
| sckOut | output | 1 | Generated bit clock |
| wsOut | output | 1 | Generated word select |
| sckOe | output | 1 | Drive enable for sckOut |
| wsOe | output | 1 | Drive enable for wsOut |
| outLeft | output | 16 | Left sample word |
| outRight | output | 16 | Right sample word |
| outValid | output | 1 | One-cycle strobe: pair updated |

## Verification
In long-frame mode, delivering the previous frame's pair and taking in the new frame's first bits can fall on the same sampling edge. Setting both the word position and the qualifier position to bit 0 provokes this. The bench drives frames whose left MSB also acts as the qualifier. It judges the case correct when the pair delivered at each frame start is the previous frame's words, and when the pair delivered at the following frame start carries the new words, with the qualifier taken from that shared bit.

// File: rtl/serAudioPkg.sv
package serAudioPkg;
  typedef enum logic [1:0] {
    MODE_STD   = 2'd0,
    MODE_LSB   = 2'd1,
    MODE_FRAME = 2'd2,
    MODE_OFF   = 2'd3
  } rxMode_t;

  typedef struct packed {
    logic shift;
    logic lsbFirst;
    logic load;
    logic capLeft;
    logic capRight;
    logic emit;
  } rxStrobe_t;
endpackage

// File: rtl/serAudioClkGen.sv
module serAudioClkGen #(
  parameter int DIV_W = 8,
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             fallEdge,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic [POS_W-1:0] wsBits,
  output logic             sckGen,
  output logic             wsGen
);
  logic [DIV_W-1:0] divCnt;
  logic [POS_W-1:0] bitCnt;
  logic             launchLevel;

  // level the clock has just before the launch (non-sampling) edge
  assign launchLevel = ~fallEdge;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      divCnt <= '0;
      bitCnt <= '0;
      sckGen <= 1'b0;
      wsGen  <= 1'b0;
    end else if (divCnt == halfDiv) begin
      divCnt <= '0;
      sckGen <= ~sckGen;
      if (sckGen == launchLevel) begin
        if (bitCnt == wsBits) begin
          bitCnt <= '0;
          wsGen  <= ~wsGen;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/serAudioCtrl.sv
module serAudioCtrl
  import serAudioPkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int POS_W       = 9,
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sckRaw,
  input  logic             wsRaw,
  input  logic             sdRaw,
  input  logic             fallEdge,
  input  rxMode_t          mode,
  input  logic [LEN_W-1:0] lenM1,
  input  logic [POS_W-1:0] startPos,
  input  logic [POS_W-1:0] qualPos,
  output rxStrobe_t        strb,
  output logic             sdBit
);
  localparam int           TOP    = SYNC_STAGES - 1;
  localparam int           CMP_W  = POS_W + 1;
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [CMP_W-1:0] WORD_C  = CMP_W'(WORD_W);

  logic [SYNC_STAGES-1:0] sckPipe, wsPipe, sdPipe;
  logic                   sckLast, wsPrev, locked;
  logic                   leftHave, rightHave, qualSeen;
  logic [POS_W-1:0]       pos, idx;
  logic                   sckNow, wsNow, bitEdge, wsChg, frameStart, active;
  logic                   inWord, firstBit, lastLeft, lastRight;
  logic [CMP_W-1:0]       idxC, startC, leftEnd, rightEnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      sckPipe <= '0;
      wsPipe  <= '0;
      sdPipe  <= '0;
      sckLast <= 1'b0;
    end else begin
      sckPipe <= {sckPipe[TOP-1:0], sckRaw};
      wsPipe  <= {wsPipe[TOP-1:0], wsRaw};
      sdPipe  <= {sdPipe[TOP-1:0], sdRaw};
      sckLast <= sckPipe[TOP];
    end
  end

  assign sckNow  = sckPipe[TOP];
  assign wsNow   = wsPipe[TOP];
  assign sdBit   = sdPipe[TOP];
  assign bitEdge = fallEdge ? (sckLast & ~sckNow) : (sckNow & ~sckLast);

  always_comb begin
    wsChg      = wsNow ^ wsPrev;
    frameStart = (mode == MODE_FRAME) ? (wsNow & ~wsPrev) : wsChg;
    if (frameStart)         idx = '0;
    else if (pos == POS_MAX) idx = POS_MAX;
    else                    idx = pos + 1'b1;
    active   = bitEdge && (locked || frameStart) && (mode != MODE_OFF);
    idxC     = {1'b0, idx};
    startC   = {1'b0, startPos};
    leftEnd  = startC + WORD_C;
    rightEnd = leftEnd + WORD_C;
    inWord   = 1'b0;
    firstBit = 1'b0;
    lastLeft = 1'b0;
    lastRight = 1'b0;
    unique case (mode)
      MODE_STD: begin
        inWord    = (idxC >= 1) && (idxC <= WORD_C);
        firstBit  = (idxC == 1);
        lastLeft  = (idxC == WORD_C) && !wsNow;
        lastRight = (idxC == WORD_C) && wsNow;
      end
      MODE_LSB: begin
        inWord    = idxC <= CMP_W'(lenM1);
        firstBit  = (idxC == 0);
        lastLeft  = (idxC == CMP_W'(lenM1)) && !wsNow;
        lastRight = (idxC == CMP_W'(lenM1)) && wsNow;
      end
      MODE_FRAME: begin
        inWord    = (idxC >= startC) && (idxC < rightEnd);
        firstBit  = (idxC == startC) || (idxC == leftEnd);
        lastLeft  = (idxC == leftEnd - 1'b1);
        lastRight = (idxC == rightEnd - 1'b1);
      end
      default: ;
    endcase
    strb.shift    = active && inWord;
    strb.load     = active && inWord && firstBit;
    strb.lsbFirst = (mode == MODE_LSB);
    strb.capLeft  = active && lastLeft;
    strb.capRight = active && lastRight;
    if (mode == MODE_FRAME)
      strb.emit = active && frameStart && locked && qualSeen && leftHave && rightHave;
    else
      strb.emit = active && lastRight && leftHave;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wsPrev    <= 1'b0;
      locked    <= 1'b0;
      pos       <= '0;
      leftHave  <= 1'b0;
      rightHave <= 1'b0;
      qualSeen  <= 1'b0;
    end else if (bitEdge) begin
      wsPrev <= wsNow;
      if (frameStart && mode != MODE_OFF) locked <= 1'b1;
      if (active) pos <= idx;
      if (strb.capLeft)
        leftHave <= 1'b1;
      else if (strb.emit || (active && frameStart && mode == MODE_FRAME))
        leftHave <= 1'b0;
      if (strb.capRight)
        rightHave <= 1'b1;
      else if (active && frameStart)
        rightHave <= 1'b0;
      if (active && mode == MODE_FRAME && idx == qualPos)
        qualSeen <= sdBit;
      else if (active && frameStart)
        qualSeen <= 1'b0;
    end
  end
endmodule

// File: rtl/serAudioDp.sv
module serAudioDp
  import serAudioPkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  rxStrobe_t         strb,
  input  logic              sdBit,
  output logic [WORD_W-1:0] outLeft,
  output logic [WORD_W-1:0] outRight,
  output logic              outValid
);
  logic [WORD_W-1:0] sh, shNext, leftHold, rightHold;

  always_comb begin
    if (strb.load)
      shNext = strb.lsbFirst ? {sdBit, {(WORD_W-1){1'b0}}} : {{(WORD_W-1){1'b0}}, sdBit};
    else
      shNext = strb.lsbFirst ? {sdBit, sh[WORD_W-1:1]} : {sh[WORD_W-2:0], sdBit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      leftHold  <= '0;
      rightHold <= '0;
      outLeft   <= '0;
      outRight  <= '0;
      outValid  <= 1'b0;
    end else begin
      if (strb.shift)    sh        <= shNext;
      if (strb.capLeft)  leftHold  <= shNext;
      if (strb.capRight) rightHold <= shNext;
      outValid <= strb.emit;
      if (strb.emit) begin
        outLeft  <= leftHold;
        outRight <= strb.capRight ? shNext : rightHold;
      end
    end
  end
endmodule

// File: rtl/serAudioRx.sv
module serAudioRx
  import serAudioPkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int POS_W       = 9,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgMaster,
  input  logic              cfgFallEdge,
  input  logic [1:0]        cfgMode,
  input  logic [LEN_W-1:0]  cfgLenM1,
  input  logic [POS_W-1:0]  cfgStart,
  input  logic [POS_W-1:0]  cfgQual,
  input  logic [DIV_W-1:0]  cfgHalfDiv,
  input  logic [POS_W-1:0]  cfgWsBits,
  input  logic              sckIn,
  input  logic              wsIn,
  input  logic              sdIn,
  output logic              sckOut,
  output logic              wsOut,
  output logic              sckOe,
  output logic              wsOe,
  output logic [WORD_W-1:0] outLeft,
  output logic [WORD_W-1:0] outRight,
  output logic              outValid
);
  rxStrobe_t strb;
  logic      sdBit, sckGen, wsGen, sckRaw, wsRaw;

  always_ff @(posedge clk) begin
    if (rst) begin
      sckOe <= 1'b0;
      wsOe  <= 1'b0;
    end else begin
      sckOe <= cfgMaster;
      wsOe  <= cfgMaster;
    end
  end

  assign sckOut = sckGen;
  assign wsOut  = wsGen;
  assign sckRaw = cfgMaster ? sckGen : sckIn;
  assign wsRaw  = cfgMaster ? wsGen : wsIn;

  serAudioClkGen #(.DIV_W(DIV_W), .POS_W(POS_W)) uGen (
    .clk(clk), .rst(rst), .enable(cfgMaster), .fallEdge(cfgFallEdge),
    .halfDiv(cfgHalfDiv), .wsBits(cfgWsBits), .sckGen(sckGen), .wsGen(wsGen)
  );

  serAudioCtrl #(.WORD_W(WORD_W), .POS_W(POS_W), .LEN_W(LEN_W),
                 .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rst(rst), .sckRaw(sckRaw), .wsRaw(wsRaw), .sdRaw(sdIn),
    .fallEdge(cfgFallEdge), .mode(rxMode_t'(cfgMode)), .lenM1(cfgLenM1),
    .startPos(cfgStart), .qualPos(cfgQual), .strb(strb), .sdBit(sdBit)
  );

  serAudioDp #(.WORD_W(WORD_W)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .sdBit(sdBit),
    .outLeft(outLeft), .outRight(outRight), .outValid(outValid)
  );
endmodule

// File: rtl/serAudioChk.sv
module serAudioChk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfgMaster,
  input logic [1:0]        cfgMode,
  input logic              sckOut,
  input logic              sckOe,
  input logic              wsOe,
  input logic [WORD_W-1:0] outLeft,
  input logic [WORD_W-1:0] outRight,
  input logic              outValid
);
  // R1: slave mode keeps both drivers disabled
  p_slave_oe_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(cfgMaster) |-> (!sckOe && !wsOe));

  // R9: generator is parked while slave
  p_slave_sck_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(cfgMaster) |-> !sckOut);

  // R7: strobe lasts one cycle
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R7: words hold outside the strobe
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(outLeft) && $stable(outRight)));

  // R8: off mode delivers nothing
  p_off_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(cfgMode) == 2'd3) |-> !outValid);
endmodule

bind serAudioRx serAudioChk #(.WORD_W(WORD_W)) uChk (
  .clk(clk), .rst(rst), .cfgMaster(cfgMaster), .cfgMode(cfgMode),
  .sckOut(sckOut), .sckOe(sckOe), .wsOe(wsOe),
  .outLeft(outLeft), .outRight(outRight), .outValid(outValid)
);

// File: tb/sim_serAudioRx.sv
module sim_serAudioRx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgMaster = 1'b0, cfgFallEdge = 1'b0;
  logic [1:0]  cfgMode = 2'd0;
  logic [3:0]  cfgLenM1 = 4'd15;
  logic [8:0]  cfgStart = '0, cfgQual = '0, cfgWsBits = '0;
  logic [7:0]  cfgHalfDiv = '0;
  logic        sckIn = 1'b0, wsIn = 1'b0, sdIn = 1'b0;
  logic        sckOut, wsOut, sckOe, wsOe, outValid;
  logic [15:0] outLeft, outRight;

  int checks = 0, errors = 0, cyc = 0;
  int vCount = 0, pulseErr = 0;
  logic        prevValid = 1'b0;
  logic [15:0] gotL = '0, gotR = '0;

  serAudioRx u0 (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst && outValid) begin
      vCount++;
      gotL = outLeft;
      gotR = outRight;
      if (prevValid) pulseErr++;
    end
    prevValid = outValid;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    sckIn = cfgFallEdge;
    wsIn = 1'b0;
    sdIn = 1'b0;
    repeat (4) @(negedge clk);
    vCount = 0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  // data changes mid-phase so only the selected edge sees it settled
  task automatic sendBit(input logic ws, input logic sd);
    sckIn = cfgFallEdge;
    repeat (2) @(negedge clk);
    wsIn = ws;
    sdIn = sd;
    repeat (2) @(negedge clk);
    sckIn = ~cfgFallEdge;
    repeat (4) @(negedge clk);
  endtask

  task automatic stdFrame(input logic [15:0] l, input logic [15:0] r);
    for (int i = 0; i < 18; i++) sendBit(1'b0, (i >= 1 && i <= 16) ? l[16-i] : 1'b1);
    for (int i = 0; i < 18; i++) sendBit(1'b1, (i >= 1 && i <= 16) ? r[16-i] : 1'b1);
  endtask

  task automatic preamble();
    for (int i = 0; i < 3; i++) sendBit(1'b1, 1'b0);
  endtask

  task automatic tReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, outValid}, 32'd0);
    check("R1 words", {outLeft, outRight}, 32'd0);
    check("R1 oe", {30'b0, sckOe, wsOe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe after", {30'b0, sckOe, wsOe}, 32'd0);
  endtask

  task automatic tStd();
    cfgMode = 2'd0; cfgFallEdge = 1'b0; cfgMaster = 1'b0;
    doReset();
    preamble();
    stdFrame(16'hA5C3, 16'h1234);
    check("R3 count1", vCount, 1);
    check("R3 pair1", {gotL, gotR}, 32'hA5C3_1234);
    stdFrame(16'hFFFE, 16'h8001);
    check("R3 count2", vCount, 2);
    check("R3 pair2", {gotL, gotR}, 32'hFFFE_8001);
    check("R7 single pulses", pulseErr, 0);
  endtask

  task automatic tFall();
    cfgMode = 2'd0; cfgFallEdge = 1'b1;
    doReset();
    preamble();
    stdFrame(16'h6B2D, 16'hC0F1);
    check("R2 fall count", vCount, 1);
    check("R2 fall pair", {gotL, gotR}, 32'h6B2D_C0F1);
    cfgFallEdge = 1'b0;
  endtask

  task automatic tLsb(input int len, input logic [15:0] l, input logic [15:0] r);
    logic [15:0] mask, expL, expR;
    cfgMode = 2'd1; cfgLenM1 = 4'(len - 1);
    doReset();
    preamble();
    for (int i = 0; i < 16; i++) sendBit(1'b0, (i < len) ? l[i] : 1'b1);
    for (int i = 0; i < 16; i++) sendBit(1'b1, (i < len) ? r[i] : 1'b1);
    mask = (len == 16) ? 16'hFFFF : 16'((32'd1 << len) - 1);
    expL = 16'((l & mask) << (16 - len));
    expR = 16'((r & mask) << (16 - len));
    check("R4 lsb count", vCount, 1);
    check("R4 lsb pair", {gotL, gotR}, {expL, expR});
  endtask

  task automatic frameBits(input int nBits, input int st, input int qp, input logic q,
                           input logic [15:0] l, input logic [15:0] r);
    logic b;
    for (int i = 0; i < nBits; i++) begin
      b = 1'b0;
      if (i >= st && i < st + 16) b = l[st + 15 - i];
      else if (i >= st + 16 && i < st + 32) b = r[st + 31 - i];
      if (i == qp) b = q;
      sendBit(i == 0, b);
    end
  endtask

  task automatic tFrame();
    cfgMode = 2'd2; cfgStart = 9'd8; cfgQual = 9'd3;
    doReset();
    frameBits(48, 8, 3, 1'b1, 16'h1F2E, 16'h3D4C);
    check("R5 none yet", vCount, 0);
    frameBits(48, 8, 3, 1'b0, 16'h5555, 16'hAAAA);
    check("R5 count A", vCount, 1);
    check("R5 pair A", {gotL, gotR}, 32'h1F2E_3D4C);
    frameBits(48, 8, 3, 1'b1, 16'h7E81, 16'h0FF0);
    check("R5 qual0 dropped", vCount, 1);
    check("R7 hold", {outLeft, outRight}, 32'h1F2E_3D4C);
    sendBit(1'b1, 1'b0);
    repeat (8) @(negedge clk);
    check("R5 count C", vCount, 2);
    check("R5 pair C", {gotL, gotR}, 32'h7E81_0FF0);
  endtask

  task automatic tFrameZero();
    cfgMode = 2'd2; cfgStart = 9'd0; cfgQual = 9'd0;
    doReset();
    frameBits(40, 0, 0, 1'b1, 16'h9ABC, 16'h1357);
    frameBits(40, 0, 0, 1'b1, 16'hC001, 16'h7FFE);
    check("R6 count1", vCount, 1);
    check("R6 pair1", {gotL, gotR}, 32'h9ABC_1357);
    sendBit(1'b1, 1'b0);
    repeat (8) @(negedge clk);
    check("R6 count2", vCount, 2);
    check("R6 pair2", {gotL, gotR}, 32'hC001_7FFE);
  endtask

  task automatic tOff();
    cfgMode = 2'd3;
    doReset();
    preamble();
    stdFrame(16'h1111, 16'h2222);
    stdFrame(16'h3333, 16'h4444);
    check("R8 off count", vCount, 0);
    check("R8 off words", {outLeft, outRight}, 32'd0);
  endtask

  task automatic tMaster();
    logic prev, prevS;
    int n, rises, guard;
    cfgMode = 2'd0; cfgFallEdge = 1'b0; cfgMaster = 1'b1;
    cfgHalfDiv = 8'd3; cfgWsBits = 9'd17;
    doReset();
    sdIn = 1'b1;
    check("R9 oe", {30'b0, sckOe, wsOe}, 32'd3);
    prev = sckOut; guard = 0;
    while (sckOut == prev && guard < 100) begin @(negedge clk); guard++; end
    prev = sckOut; n = 0;
    while (sckOut == prev && n < 100) begin @(negedge clk); n++; end
    check("R9 half period", n, 4);
    prev = wsOut; guard = 0;
    while (wsOut == prev && guard < 2000) begin @(negedge clk); guard++; end
    prev = wsOut; prevS = sckOut; rises = 0; guard = 0;
    while (wsOut == prev && guard < 2000) begin
      @(negedge clk); guard++;
      if (sckOut && !prevS) rises++;
      prevS = sckOut;
    end
    check("R9 ws half", rises, 18);
    guard = 0;
    while (vCount == 0 && guard < 3000) begin @(negedge clk); guard++; end
    check("R9 loop pair", {gotL, gotR}, 32'hFFFF_FFFF);
    cfgMaster = 1'b0;
  endtask

  initial begin
    tReset();
    tStd();
    tFall();
    tLsb(12, 16'h0ABC, 16'h0F35);
    tLsb(16, 16'hBEEF, 16'h1234);
    tLsb(1, 16'h0001, 16'h0000);
    tFrame();
    tFrameZero();
    tOff();
    tMaster();
    check("R7 single pulses end", pulseErr, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule